// File: doc/BRIEF.md
# Cascadable Four-Mode Shift Register

This block is a register built from identical narrow slices. A two-bit mode code is sampled on every rising clock edge and picks one of four actions: keep the stored value, move every bit one place toward the high end, move every bit one place toward the low end, or load a full word from the parallel data bus. Each shift direction has its own serial input. The bit shifted in from outside enters at the end the data moves away from.

Slices are chained by cross-wiring their end bits. The top bit of a lower slice feeds the low-end serial input of the slice above it. The bottom bit of a higher slice feeds the high-end serial input of the slice below it. The default build chains two 4-bit slices into an 8-bit register.

The shared data lines of the 8-bit version are modelled as a separate input bus and output bus with an output-enable. The block forces the output-enable low while the mode code asks for a load, so the register never drives the lines it is reading. A synchronous active-high reset clears every bit and takes priority over any mode.

Top module: `usr_cascade`

## Requirements
- R1: While `rst` is high at a rising edge, every bit of `q` becomes 0, whatever the mode code and data inputs are.
- R2: Mode code 2'b00 (hold) leaves `q` unchanged across the edge.
- R3: Mode code 2'b01 (shift toward high end): `q[0]` takes `ser_r_in` and each `q[i]` for i>0 takes the old `q[i-1]`.
- R4: Mode code 2'b10 (shift toward low end): `q[7]` takes `ser_l_in` and each `q[i]` for i<7 takes the old `q[i+1]`.
- R5: Mode code 2'b11 (load): `q` takes the value on `bus_in`.
- R6: Bits cross the slice boundary without a gap. A high-end shift moves the old `q[3]` into `q[4]`, and a low-end shift moves the old `q[4]` into `q[3]`.
- R7: `bus_oe` is high exactly when `oe_req` is high and the mode code is not 2'b11. It follows the inputs within the same cycle.
- R8: `bus_out` equals `q` while `bus_oe` is high and is all zeros while it is low.
- R9: `hi_end_out` always equals `q[7]` and `lo_end_out` always equals `q[0]`.
- R10: In every mode except load, the value on `bus_in` has no effect on `q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | 00 hold, 01 shift toward high end, 10 shift toward low end, 11 load |
| ser_r_in | input | 1 | Serial bit entering `q[0]` on a high-end shift |
| ser_l_in | input | 1 | Serial bit entering `q[7]` on a low-end shift |
| oe_req | input | 1 | Request to drive the shared data lines |
| bus_in | input | 8 | Parallel load data |
| bus_out | output | 8 | Register contents driven onto the data lines |
| bus_oe | output | 1 | Output-enable for the data lines |
| q | output | 8 | Parallel register contents |
| hi_end_out | output | 1 | Top bit, for chaining further up |
| lo_end_out | output | 1 | Bottom bit, for chaining further down |

## Verification
The register contents `q` and the two end bits change one clock edge after the mode code and serial or parallel data are applied. The bench drives all inputs on a falling edge and reads the results on the next falling edge, so exactly one rising edge lies between a stimulus and its check. `bus_oe` and `bus_out` depend on the current inputs through logic only, so the bench checks them after a short settle delay in the same half-cycle in which the inputs were applied, before any edge.

// File: rtl/usr_pkg.sv
package usr_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD  = 2'b00,
    MODE_UP    = 2'b01,
    MODE_DOWN  = 2'b10,
    MODE_LOAD  = 2'b11
  } shift_mode_e;
endpackage

// File: rtl/usr_slice.sv
module usr_slice
  import usr_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  shift_mode_e      mode,
  input  logic             up_in,
  input  logic             down_in,
  input  logic [WIDTH-1:0] par_in,
  output logic [WIDTH-1:0] q
);
  localparam int EXT_W = WIDTH + 2;

  // neighbour view: bit 0 is the up-shift entry, bit EXT_W-1 the down-shift entry
  logic [EXT_W-1:0] ext;
  logic [WIDTH-1:0] nxt;

  assign ext = {down_in, q, up_in};

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_comb begin
      unique case (mode)
        MODE_HOLD: nxt[i] = q[i];
        MODE_UP:   nxt[i] = ext[i];
        MODE_DOWN: nxt[i] = ext[i+2];
        default:   nxt[i] = par_in[i];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end
endmodule

// File: rtl/usr_bus_gate.sv
module usr_bus_gate
  import usr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  shift_mode_e      mode,
  input  logic             oe_req,
  input  logic [WIDTH-1:0] q,
  output logic             bus_oe,
  output logic [WIDTH-1:0] bus_out
);
  always_comb begin
    bus_oe  = oe_req && (mode != MODE_LOAD);
    bus_out = bus_oe ? q : '0;
  end
endmodule

// File: rtl/usr_cascade.sv
module usr_cascade
  import usr_pkg::*;
#(
  parameter int SLICE_W  = 4,
  parameter int N_SLICES = 2,
  localparam int TOTAL_W = SLICE_W * N_SLICES
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         mode,
  input  logic               ser_r_in,
  input  logic               ser_l_in,
  input  logic               oe_req,
  input  logic [TOTAL_W-1:0] bus_in,
  output logic [TOTAL_W-1:0] bus_out,
  output logic               bus_oe,
  output logic [TOTAL_W-1:0] q,
  output logic               hi_end_out,
  output logic               lo_end_out
);
  shift_mode_e mode_e;
  logic [N_SLICES-1:0] up_link;
  logic [N_SLICES-1:0] down_link;

  assign mode_e = shift_mode_e'(mode);

  for (genvar k = 0; k < N_SLICES; k++) begin : g_slice
    if (k == 0) begin : g_lo
      assign up_link[k] = ser_r_in;
    end else begin : g_up
      assign up_link[k] = q[k*SLICE_W-1];
    end
    if (k == N_SLICES-1) begin : g_hi
      assign down_link[k] = ser_l_in;
    end else begin : g_dn
      assign down_link[k] = q[(k+1)*SLICE_W];
    end

    usr_slice #(.WIDTH(SLICE_W)) slice_i (
      .clk     (clk),
      .rst     (rst),
      .mode    (mode_e),
      .up_in   (up_link[k]),
      .down_in (down_link[k]),
      .par_in  (bus_in[k*SLICE_W +: SLICE_W]),
      .q       (q[k*SLICE_W +: SLICE_W])
    );
  end

  usr_bus_gate #(.WIDTH(TOTAL_W)) gate_i (
    .mode    (mode_e),
    .oe_req  (oe_req),
    .q       (q),
    .bus_oe  (bus_oe),
    .bus_out (bus_out)
  );

  assign hi_end_out = q[TOTAL_W-1];
  assign lo_end_out = q[0];
endmodule

// File: rtl/usr_cascade_chk.sv
module usr_cascade_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic [1:0]   mode,
  input logic         ser_r_in,
  input logic         ser_l_in,
  input logic         oe_req,
  input logic [W-1:0] bus_in,
  input logic [W-1:0] bus_out,
  input logic         bus_oe,
  input logic [W-1:0] q,
  input logic         hi_end_out,
  input logic         lo_end_out
);
  // R1
  reset_clears_chk: assert property (@(posedge clk) rst |=> (q == '0));
  // R2
  hold_keeps_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b00) |=> (q == $past(q)));
  // R3
  shift_up_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b01) |=> (q == {$past(q[W-2:0]), $past(ser_r_in)}));
  // R4
  shift_down_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b10) |=> (q == {$past(ser_l_in), $past(q[W-1:1])}));
  // R5
  load_takes_bus_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b11) |=> (q == $past(bus_in)));
  // R7
  no_drive_on_load_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_oe == (oe_req && (mode != 2'b11))));
  // R8
  bus_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    bus_out == (bus_oe ? q : '0));
  // R9
  end_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (hi_end_out == q[W-1]) && (lo_end_out == q[0]));
endmodule

bind usr_cascade usr_cascade_chk #(.W(TOTAL_W)) chk_i (.*);

// File: tb/usr_cascade_tb.sv
module usr_cascade_tb_top;
  localparam int CLK_P = 10;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst;
  logic [1:0]   mode;
  logic         ser_r_in, ser_l_in, oe_req;
  logic [W-1:0] bus_in, bus_out, q;
  logic         bus_oe, hi_end_out, lo_end_out;

  int n_vec = 0;
  int n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  usr_cascade dut_i (
    .clk(clk), .rst(rst), .mode(mode), .ser_r_in(ser_r_in), .ser_l_in(ser_l_in),
    .oe_req(oe_req), .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
    .q(q), .hi_end_out(hi_end_out), .lo_end_out(lo_end_out)
  );

  // fields: mode[19:18] ser_r[17] ser_l[16] bus_in[15:8] expected q[7:0]
  localparam logic [19:0] VEC [12] = '{
    {2'b11, 1'b0, 1'b0, 8'hA5, 8'hA5},  // R5 load
    {2'b00, 1'b0, 1'b0, 8'hFF, 8'hA5},  // R2 hold, R10 bus ignored
    {2'b01, 1'b1, 1'b0, 8'h00, 8'h4B},  // R3
    {2'b01, 1'b0, 1'b1, 8'hFF, 8'h96},  // R3, R10
    {2'b10, 1'b0, 1'b1, 8'h00, 8'hCB},  // R4
    {2'b10, 1'b1, 1'b0, 8'h33, 8'h65},  // R4, R10
    {2'b11, 1'b0, 1'b0, 8'h0F, 8'h0F},  // R5
    {2'b01, 1'b0, 1'b0, 8'h00, 8'h1E},  // R6 q[3] into q[4]
    {2'b10, 1'b0, 1'b0, 8'h00, 8'h0F},  // R6 q[4] into q[3]
    {2'b10, 1'b0, 1'b0, 8'h00, 8'h07},  // R4
    {2'b00, 1'b1, 1'b1, 8'h00, 8'h07},  // R2
    {2'b11, 1'b0, 1'b0, 8'h80, 8'h80}   // R5
  };

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [1:0] m, input logic sr, input logic sl, input logic [W-1:0] d);
    mode = m; ser_r_in = sr; ser_l_in = sl; bus_in = d;
    @(negedge clk);
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_P * 5000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [W-1:0] ref_q;
    logic [W-1:0] pat;
    rst = 1'b1; mode = 2'b11; ser_r_in = 1'b1; ser_l_in = 1'b1; oe_req = 1'b1; bus_in = 8'hFF;
    @(negedge clk); @(negedge clk);
    // R1: reset wins over a load request
    check("R1", q, 8'h00);
    rst = 1'b0;

    for (int i = 0; i < 12; i++) begin
      apply(VEC[i][19:18], VEC[i][17], VEC[i][16], VEC[i][15:8]);
      check("R2-R6/R10 table", q, VEC[i][7:0]);
      check("R9 hi end", {7'd0, hi_end_out}, {7'd0, VEC[i][7]});
      check("R9 lo end", {7'd0, lo_end_out}, {7'd0, VEC[i][0]});
    end

    // R7/R8: gate checks, q = 80 here
    mode = 2'b11; oe_req = 1'b1; #1;
    check("R7 load blocks oe", {7'd0, bus_oe}, 8'd0);
    check("R8 bus quiet", bus_out, 8'h00);
    mode = 2'b00; #1;
    check("R7 oe on", {7'd0, bus_oe}, 8'd1);
    check("R8 bus drives q", bus_out, 8'h80);
    oe_req = 1'b0; #1;
    check("R7 no request", {7'd0, bus_oe}, 8'd0);
    check("R8 bus quiet", bus_out, 8'h00);
    oe_req = 1'b1;

    // eight up shifts then eight down shifts against a bench model (R3, R4, R6)
    apply(2'b11, 1'b0, 1'b0, 8'h3C);
    ref_q = 8'h3C;
    pat = 8'b1101_0010;
    for (int i = 0; i < 8; i++) begin
      apply(2'b01, pat[i], ~pat[i], 8'hFF);
      ref_q = {ref_q[6:0], pat[i]};
      check("R3 up run", q, ref_q);
    end
    for (int i = 0; i < 8; i++) begin
      apply(2'b10, ~pat[7-i], pat[7-i], 8'h00);
      ref_q = {pat[7-i], ref_q[7:1]};
      check("R4 down run", q, ref_q);
    end

    // R1: synchronous reset in mid-run with a shift requested
    rst = 1'b1;
    apply(2'b01, 1'b1, 1'b1, 8'hFF);
    check("R1 reset mid-run", q, 8'h00);
    rst = 1'b0;
    apply(2'b00, 1'b0, 1'b0, 8'hFF);
    check("R1 stays clear", q, 8'h00);

    finish_run();
  end
endmodule